// File: doc/BRIEF.md
# Segmented TLP Transmit Packer

The packer takes transaction-layer packets from an upstream source one 256-bit beat at a time and lays them out on a transmit bus made of four 256-bit segments. On its first beat, each packet carries a 128-bit header, an optional 32-bit prefix and its payload length in beats. The packer frames the packet itself: it marks the first beat as the start and counts down the declared length to find the last beat. The beats are held in an internal buffer. A packet is scheduled onto the bus only after every one of its beats has arrived. This means that once a packet has started, the packer never runs dry in the middle of it.

Every bus word is built by walking the segments in order. An open packet continues in the next segment. A new packet may open only in segment 0 or segment 2, so a segment that would hold an illegal start is left empty. Several short packets can therefore share one word. For every segment the block drives data, header, prefix, start, end, and three qualifiers: data-valid, header-valid and prefix-valid. It also drives even parity for the data, header and prefix, one bit per dword. A single ready input from the consumer freezes the whole output word and all scheduling state while it is low.

Top module: `tlp_seg_packer`

## Requirements
- R1: Out of reset, every segment's start, end and valid flags are low, all parity bits are low, and the input accepts beats (in_ready high).
- R2: Start, end, header-valid and prefix-valid appear only on segments whose data-valid is set. A packet's first beat carries the start flag and its last beat the end flag. The number of beats between them equals the declared length, so a one-beat packet has both flags in the same segment.
- R3: A start flag appears only on segment 0 or segment 2. After an end in segment 0 the next packet starts no earlier than segment 2, and after an end in segment 2 it starts no earlier than segment 0 of the next word. The skipped segment has data-valid low.
- R4: Between a packet's start and its end, every consumed segment carries that packet's next beat. There are no empty segments and no empty words, even across word boundaries.
- R5: A fully buffered packet starts at the earliest legal segment of the current word. Several packets may therefore share one word.
- R6: Header-valid is set exactly on start segments. Those segments carry the header given with the packet's first beat. The header lanes of every other segment are zero.
- R7: Prefix-valid is set on a start segment only when the packet was given with its prefix-enable bit set. The prefix lane then carries the given prefix; in every other case the prefix lane is all zeros.
- R8: Each parity bit is the XOR of one 32-bit dword of the driven value. Data parity bit k of a segment covers that segment's data bits 32k+31 down to 32k. The header has 4 such bits per segment and the prefix has 1.
- R9: While tx_ready is low, all outputs hold their values and no buffered beat is consumed.
- R10: A packet appears on the bus only after all its beats have been accepted. in_ready falls once the buffer holds DEPTH beats. Lengths run from 1 to DEPTH, and a declared length of 0 is treated as 1.
- R11: Beats leave in the order they arrived, with their data unchanged, and no beat is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Buffer can take a beat |
| in_len | input | $clog2(DEPTH+1) | Payload length in beats, read on a packet's first beat |
| in_hdr | input | 128 | Header, read on a packet's first beat |
| in_pfx_en | input | 1 | Packet carries a prefix, read on a packet's first beat |
| in_pfx | input | 32 | Prefix word, read on a packet's first beat |
| in_data | input | SEG_W | Payload beat |
| tx_ready | input | 1 | Consumer takes the current word at this edge |
| tx_data | output | SEGS*SEG_W | Segment data, segment s at bits s*SEG_W upward |
| tx_hdr | output | SEGS*128 | Segment headers |
| tx_pfx | output | SEGS*32 | Segment prefixes |
| tx_sop | output | SEGS | Packet start per segment |
| tx_eop | output | SEGS | Packet end per segment |
| tx_dvalid | output | SEGS | Data valid per segment |
| tx_hvalid | output | SEGS | Header valid per segment |
| tx_pvalid | output | SEGS | Prefix valid per segment |
| tx_data_par | output | SEGS*SEG_W/32 | Data parity, one bit per dword |
| tx_hdr_par | output | SEGS*4 | Header parity |
| tx_pfx_par | output | SEGS | Prefix parity |

## Verification
A wrong carried "packet open" bit between words shows up in the very next consumed word. It appears either as a continuation segment with no open packet or as a start flag on top of an open packet. A stale buffer pointer or complete-packet count shows as reordered or duplicated payload at the scoreboard, or as a packet starting before its last beat arrived. Both are visible within the word in which the bad state is first used. Exact layouts are checked for runs of short and long packets queued behind a stalled consumer, so a misplaced start or a missing pad appears as a layout mismatch within the first two or three words.

// File: rtl/tlp_pack_pkg.sv
// Shared constants and the per-beat side information kept in the buffer.
// Assumes the header and prefix widths are fixed by the packet format.
package tlp_pack_pkg;
    localparam int DW_W  = 32;
    localparam int HDR_W = 128;
    localparam int PFX_W = 32;

    typedef struct packed {
        logic             eop;
        logic             pfx_en;
        logic [HDR_W-1:0] hdr;
        logic [PFX_W-1:0] pfx;
    } beat_meta_t;
endpackage

// File: rtl/tpk_parity.sv
// Even parity generator: one XOR bit per 32-bit dword of a word.
// Assumes W is a multiple of 32.
module tpk_parity #(
    parameter int W = 256
) (
    input  logic [W-1:0]    word,
    output logic [W/32-1:0] par
);
    localparam int NDW = W / 32;

    // one reduction XOR per dword
    for (genvar k = 0; k < NDW; k++) begin : g_dw
        assign par[k] = ^word[k*32 +: 32];
    end
endmodule

// File: rtl/tpk_beat_fifo.sv
// Beat buffer: one push per cycle, up to SEGS pops per cycle, peeks the
// oldest SEGS entries and counts how many complete packets it holds.
// Assumes DEPTH is a power of two and larger than SEGS, and that the
// caller never pops more than it holds.
module tpk_beat_fifo
    import tlp_pack_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEG_W = 256,
    parameter int SEGS  = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SEG_W-1:0] push_data,
    input  beat_meta_t       push_meta,
    input  logic [CNT_W-1:0] pop_n,
    input  logic [CNT_W-1:0] eop_n,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cpl_cnt,
    output logic [SEG_W-1:0] peek_data [SEGS],
    output beat_meta_t       peek_meta [SEGS]
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [SEG_W-1:0] data_mem [DEPTH];
    beat_meta_t       meta_mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (push) begin
            data_mem[wr_ptr] <= push_data;
            meta_mem[wr_ptr] <= push_meta;
        end
    end

    // pointers, occupancy and complete-packet count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            cpl_cnt <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            rd_ptr  <= rd_ptr + pop_n[PTR_W-1:0];
            count   <= count + CNT_W'(push) - pop_n;
            cpl_cnt <= cpl_cnt + CNT_W'(push && push_meta.eop) - eop_n;
        end
    end

    // oldest SEGS entries, in order
    for (genvar i = 0; i < SEGS; i++) begin : g_peek
        assign peek_data[i] = data_mem[rd_ptr + PTR_W'(i)];
        assign peek_meta[i] = meta_mem[rd_ptr + PTR_W'(i)];
    end
endmodule

// File: rtl/tpk_seg_sched.sv
// Segment scheduler: decides, for one output word, which buffered beat
// goes into each segment. An open packet fills segments in order; a new
// packet opens only on a segment index that is a multiple of START_STRIDE
// and only if it is completely buffered. Assumes a completely buffered
// packet always has all of its beats present in the peek window order.
module tpk_seg_sched #(
    parameter int SEGS         = 4,
    parameter int START_STRIDE = 2,
    parameter int CNT_W        = 5,
    parameter int IDX_W        = 2
) (
    input  logic             busy_q,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cpl_cnt,
    input  logic [SEGS-1:0]  peek_eop,
    output logic [SEGS-1:0]  take,
    output logic [SEGS-1:0]  is_sop,
    output logic [SEGS-1:0]  is_eop,
    output logic [IDX_W-1:0] idx [SEGS],
    output logic [CNT_W-1:0] pop_n,
    output logic [CNT_W-1:0] eop_n,
    output logic             busy_d
);
    // walk the segments in order, carrying open state and consumption
    always_comb begin
        logic             bsy;
        logic [CNT_W-1:0] off;
        logic [CNT_W-1:0] eops;
        bsy  = busy_q;
        off  = '0;
        eops = '0;
        for (int s = 0; s < SEGS; s++) begin
            take[s]   = 1'b0;
            is_sop[s] = 1'b0;
            is_eop[s] = 1'b0;
            idx[s]    = off[IDX_W-1:0];
            if (bsy) begin
                take[s]   = 1'b1;
                is_eop[s] = peek_eop[off[IDX_W-1:0]];
            end else if ((s % START_STRIDE) == 0 && cpl_cnt > eops && count > off) begin
                take[s]   = 1'b1;
                is_sop[s] = 1'b1;
                is_eop[s] = peek_eop[off[IDX_W-1:0]];
            end
            if (take[s]) begin
                off = off + CNT_W'(1);
                if (is_eop[s]) begin
                    bsy  = 1'b0;
                    eops = eops + CNT_W'(1);
                end else begin
                    bsy = 1'b1;
                end
            end
        end
        pop_n  = off;
        eop_n  = eops;
        busy_d = bsy;
    end
endmodule

// File: rtl/tlp_seg_packer.sv
// Segmented transmit packer top. Frames incoming beats by the declared
// length, buffers them, schedules complete packets onto SEGS segments and
// registers the resulting word. Parity is formed from the registered word.
// Assumes declared lengths do not exceed DEPTH and that SEGS < DEPTH.
module tlp_seg_packer
    import tlp_pack_pkg::*;
#(
    parameter int SEGS         = 4,
    parameter int SEG_W        = 256,
    parameter int DEPTH        = 16,
    parameter int START_STRIDE = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [$clog2(DEPTH+1)-1:0]   in_len,
    input  logic [HDR_W-1:0]             in_hdr,
    input  logic                         in_pfx_en,
    input  logic [PFX_W-1:0]             in_pfx,
    input  logic [SEG_W-1:0]             in_data,
    input  logic                         tx_ready,
    output logic [SEGS*SEG_W-1:0]        tx_data,
    output logic [SEGS*HDR_W-1:0]        tx_hdr,
    output logic [SEGS*PFX_W-1:0]        tx_pfx,
    output logic [SEGS-1:0]              tx_sop,
    output logic [SEGS-1:0]              tx_eop,
    output logic [SEGS-1:0]              tx_dvalid,
    output logic [SEGS-1:0]              tx_hvalid,
    output logic [SEGS-1:0]              tx_pvalid,
    output logic [SEGS*SEG_W/DW_W-1:0]   tx_data_par,
    output logic [SEGS*HDR_W/DW_W-1:0]   tx_hdr_par,
    output logic [SEGS*PFX_W/DW_W-1:0]   tx_pfx_par
);
    localparam int LEN_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (SEGS > 1) ? $clog2(SEGS) : 1;
    localparam int DPS   = SEG_W / DW_W;
    localparam int HPS   = HDR_W / DW_W;
    localparam int PPS   = PFX_W / DW_W;

    // ---------------- input framing ----------------
    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] rem_d;
    logic [LEN_W-1:0] eff_len;
    logic             first_beat;
    logic             beat_eop;
    logic             in_fire;
    logic [LEN_W-1:0] fifo_count;
    logic [LEN_W-1:0] fifo_cpl;
    beat_meta_t       push_meta;

    assign in_ready = (fifo_count < LEN_W'(DEPTH));
    assign in_fire  = in_valid && in_ready;

    // derive start/end of each accepted beat from the remaining count
    always_comb begin
        first_beat = (rem_q == '0);
        eff_len    = (in_len == '0) ? LEN_W'(1) : in_len;
        beat_eop   = first_beat ? (eff_len == LEN_W'(1)) : (rem_q == LEN_W'(1));
        rem_d      = first_beat ? (eff_len - LEN_W'(1)) : (rem_q - LEN_W'(1));
        push_meta.eop    = beat_eop;
        push_meta.pfx_en = in_pfx_en;
        push_meta.hdr    = in_hdr;
        push_meta.pfx    = in_pfx;
    end

    // remaining-beat counter of the packet being received
    always_ff @(posedge clk) begin
        if (!rst_n)       rem_q <= '0;
        else if (in_fire) rem_q <= rem_d;
    end

    // ---------------- buffer ----------------
    logic [SEG_W-1:0] peek_data [SEGS];
    beat_meta_t       peek_meta [SEGS];
    logic [LEN_W-1:0] pop_n;
    logic [LEN_W-1:0] eop_n;
    logic [LEN_W-1:0] pop_g;
    logic [LEN_W-1:0] eop_g;

    assign pop_g = tx_ready ? pop_n : '0;
    assign eop_g = tx_ready ? eop_n : '0;

    tpk_beat_fifo #(
        .DEPTH (DEPTH),
        .SEG_W (SEG_W),
        .SEGS  (SEGS),
        .CNT_W (LEN_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_fire),
        .push_data (in_data),
        .push_meta (push_meta),
        .pop_n     (pop_g),
        .eop_n     (eop_g),
        .count     (fifo_count),
        .cpl_cnt   (fifo_cpl),
        .peek_data (peek_data),
        .peek_meta (peek_meta)
    );

    // ---------------- scheduling ----------------
    logic [SEGS-1:0]  peek_eop;
    logic [SEGS-1:0]  take;
    logic [SEGS-1:0]  is_sop;
    logic [SEGS-1:0]  is_eop;
    logic [IDX_W-1:0] idx [SEGS];
    logic             busy_q;
    logic             busy_d;

    for (genvar s = 0; s < SEGS; s++) begin : g_eop
        assign peek_eop[s] = peek_meta[s].eop;
    end

    tpk_seg_sched #(
        .SEGS         (SEGS),
        .START_STRIDE (START_STRIDE),
        .CNT_W        (LEN_W),
        .IDX_W        (IDX_W)
    ) u_sched (
        .busy_q   (busy_q),
        .count    (fifo_count),
        .cpl_cnt  (fifo_cpl),
        .peek_eop (peek_eop),
        .take     (take),
        .is_sop   (is_sop),
        .is_eop   (is_eop),
        .idx      (idx),
        .pop_n    (pop_n),
        .eop_n    (eop_n),
        .busy_d   (busy_d)
    );

    // ---------------- output word ----------------
    logic [SEGS-1:0][SEG_W-1:0] out_data;
    logic [SEGS-1:0][HDR_W-1:0] out_hdr;
    logic [SEGS-1:0][PFX_W-1:0] out_pfx;
    logic [SEGS-1:0]            out_sop;
    logic [SEGS-1:0]            out_eop;
    logic [SEGS-1:0]            out_dv;
    logic [SEGS-1:0]            out_hv;
    logic [SEGS-1:0]            out_pv;

    // load the next word when the consumer takes the current one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_hdr  <= '0;
            out_pfx  <= '0;
            out_sop  <= '0;
            out_eop  <= '0;
            out_dv   <= '0;
            out_hv   <= '0;
            out_pv   <= '0;
            busy_q   <= 1'b0;
        end else if (tx_ready) begin
            busy_q <= busy_d;
            for (int s = 0; s < SEGS; s++) begin
                beat_meta_t m;
                logic       pv;
                m  = peek_meta[idx[s]];
                pv = take[s] && is_sop[s] && m.pfx_en;
                out_dv[s]   <= take[s];
                out_sop[s]  <= is_sop[s];
                out_eop[s]  <= is_eop[s];
                out_hv[s]   <= is_sop[s];
                out_pv[s]   <= pv;
                out_data[s] <= take[s] ? peek_data[idx[s]] : '0;
                out_hdr[s]  <= is_sop[s] ? m.hdr : '0;
                out_pfx[s]  <= pv ? m.pfx : '0;
            end
        end
    end

    assign tx_data   = out_data;
    assign tx_hdr    = out_hdr;
    assign tx_pfx    = out_pfx;
    assign tx_sop    = out_sop;
    assign tx_eop    = out_eop;
    assign tx_dvalid = out_dv;
    assign tx_hvalid = out_hv;
    assign tx_pvalid = out_pv;

    // ---------------- parity ----------------
    for (genvar s = 0; s < SEGS; s++) begin : g_par
        tpk_parity #(.W(SEG_W)) u_dpar (
            .word (out_data[s]),
            .par  (tx_data_par[s*DPS +: DPS])
        );
        tpk_parity #(.W(HDR_W)) u_hpar (
            .word (out_hdr[s]),
            .par  (tx_hdr_par[s*HPS +: HPS])
        );
        tpk_parity #(.W(PFX_W)) u_ppar (
            .word (out_pfx[s]),
            .par  (tx_pfx_par[s*PPS +: PPS])
        );
    end
endmodule

// File: rtl/tpk_checker.sv
// Protocol checker bound to the packer top: start positions, flag
// qualification, framing continuity across words, header zeroing,
// prefix qualification and output hold under a stalled consumer.
module tpk_checker
    import tlp_pack_pkg::*;
#(
    parameter int SEGS         = 4,
    parameter int SEG_W        = 256,
    parameter int START_STRIDE = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tx_ready,
    input logic [SEGS*SEG_W-1:0] tx_data,
    input logic [SEGS*HDR_W-1:0] tx_hdr,
    input logic [SEGS*PFX_W-1:0] tx_pfx,
    input logic [SEGS-1:0]       tx_sop,
    input logic [SEGS-1:0]       tx_eop,
    input logic [SEGS-1:0]       tx_dvalid,
    input logic [SEGS-1:0]       tx_hvalid,
    input logic [SEGS-1:0]       tx_pvalid
);
    logic [SEGS-1:0] legal_start;
    logic            open_q;
    logic            open_d;
    logic            frame_err;
    logic            hdr_leak;

    for (genvar s = 0; s < SEGS; s++) begin : g_mask
        assign legal_start[s] = ((s % START_STRIDE) == 0);
    end

    // framing walk over the presented word
    always_comb begin
        logic o;
        o         = open_q;
        frame_err = 1'b0;
        hdr_leak  = 1'b0;
        for (int s = 0; s < SEGS; s++) begin
            if (o) begin
                if (!tx_dvalid[s] || tx_sop[s]) frame_err = 1'b1;
                if (tx_dvalid[s] && tx_eop[s]) o = 1'b0;
            end else if (tx_dvalid[s]) begin
                if (!tx_sop[s]) frame_err = 1'b1;
                o = !tx_eop[s];
            end
            if (!tx_hvalid[s] && tx_hdr[s*HDR_W +: HDR_W] != '0) hdr_leak = 1'b1;
        end
        open_d = o;
    end

    // open state carried across consumed words
    always_ff @(posedge clk) begin
        if (!rst_n)        open_q <= 1'b0;
        else if (tx_ready) open_q <= open_d;
    end

    AST_START_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sop & ~legal_start) == '0);                                  // R3
    AST_FLAG_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_sop | tx_eop | tx_hvalid | tx_pvalid) & ~tx_dvalid) == '0); // R2
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_err);                                                     // R4
    AST_HDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_leak);                                                      // R6
    AST_PFX_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pvalid & ~tx_hvalid) == '0);                                 // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |=> $stable({tx_data, tx_hdr, tx_pfx, tx_sop, tx_eop,
                               tx_dvalid, tx_hvalid, tx_pvalid}));       // R9
endmodule

bind tlp_seg_packer tpk_checker #(
    .SEGS         (SEGS),
    .SEG_W        (SEG_W),
    .START_STRIDE (START_STRIDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_hdr    (tx_hdr),
    .tx_pfx    (tx_pfx),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop),
    .tx_dvalid (tx_dvalid),
    .tx_hvalid (tx_hvalid),
    .tx_pvalid (tx_pvalid)
);

// File: tb/sim_tlp_seg_packer.sv
`timescale 1ns/1ps
module sim_tlp_seg_packer;
    localparam int SEGS  = 4;
    localparam int SEG_W = 256;
    localparam int DEPTH = 16;
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [LEN_W-1:0] in_len = '0;
    logic [127:0] in_hdr = '0;
    logic in_pfx_en = 1'b0;
    logic [31:0] in_pfx = '0;
    logic [SEG_W-1:0] in_data = '0;
    logic tx_ready = 1'b0;
    logic [SEGS*SEG_W-1:0] tx_data;
    logic [SEGS*128-1:0] tx_hdr;
    logic [SEGS*32-1:0] tx_pfx;
    logic [SEGS-1:0] tx_sop, tx_eop, tx_dvalid, tx_hvalid, tx_pvalid;
    logic [SEGS*8-1:0] tx_data_par;
    logic [SEGS*4-1:0] tx_hdr_par;
    logic [SEGS-1:0] tx_pfx_par;

    always #4 clk = ~clk;

    tlp_seg_packer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_len(in_len), .in_hdr(in_hdr), .in_pfx_en(in_pfx_en), .in_pfx(in_pfx),
        .in_data(in_data), .tx_ready(tx_ready), .tx_data(tx_data), .tx_hdr(tx_hdr),
        .tx_pfx(tx_pfx), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_dvalid(tx_dvalid),
        .tx_hvalid(tx_hvalid), .tx_pvalid(tx_pvalid), .tx_data_par(tx_data_par),
        .tx_hdr_par(tx_hdr_par), .tx_pfx_par(tx_pfx_par)
    );

    typedef struct {
        logic [255:0] data;
        logic         sop;
        logic         eop;
        logic [127:0] hdr;
        logic         pe;
        logic [31:0]  pfx;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] lay_q[$];
    int total = 0;
    int bad   = 0;
    bit open_b = 1'b0;
    bit prev_rdy = 1'b1;
    bit tog_on = 1'b0;
    logic [SEGS*(256+128+32+5)-1:0] snap;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] xpar(input logic [255:0] d, input int n);
        logic [7:0] r = '0;
        for (int k = 0; k < n; k++) r[k] = ^d[k*32 +: 32];
        return r;
    endfunction

    // monitor: compares every consumed segment against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            logic [SEGS*(256+128+32+5)-1:0] cur;
            cur = {tx_data, tx_hdr, tx_pfx, tx_sop, tx_eop, tx_dvalid, tx_hvalid, tx_pvalid};
            if (!prev_rdy) chk(cur == snap, "R9 hold", 256'(tx_dvalid), 256'(snap[SEGS*3-1:0]));
            snap = cur;
            prev_rdy = tx_ready;
            if (tx_ready && tx_dvalid != '0) begin
                logic [31:0] code;
                code = "....";
                for (int s = 0; s < SEGS; s++) begin
                    if (tx_dvalid[s]) begin
                        exp_t e;
                        logic [255:0] d;
                        logic [127:0] h;
                        logic [31:0]  p;
                        d = tx_data[s*256 +: 256];
                        h = tx_hdr[s*128 +: 128];
                        p = tx_pfx[s*32 +: 32];
                        code[31-8*s -: 8] = tx_sop[s] ? (tx_eop[s] ? "B" : "S") : (tx_eop[s] ? "E" : "C");
                        chk(!(tx_sop[s] && (s % 2) != 0), "R3 start segment", 256'(s), 256'(0));
                        chk(open_b != tx_sop[s], "R4 continuity", 256'(tx_sop[s]), 256'(!open_b));
                        open_b = !tx_eop[s];
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R11 extra beat", d, 256'(0));
                        end else begin
                            e = exp_q.pop_front();
                            chk(d == e.data, "R11 data", d, e.data);
                            chk(tx_sop[s] == e.sop && tx_eop[s] == e.eop, "R2 sop/eop",
                                256'({tx_sop[s], tx_eop[s]}), 256'({e.sop, e.eop}));
                            chk(tx_hvalid[s] == e.sop && h == (e.sop ? e.hdr : 128'h0), "R6 header",
                                256'(h), 256'(e.hdr));
                            chk(tx_pvalid[s] == (e.sop && e.pe) && p == ((e.sop && e.pe) ? e.pfx : 32'h0),
                                "R7 prefix", 256'(p), 256'(e.pfx));
                            chk(tx_data_par[s*8 +: 8] == xpar(e.data, 8), "R8 data parity",
                                256'(tx_data_par[s*8 +: 8]), 256'(xpar(e.data, 8)));
                            chk(tx_hdr_par[s*4 +: 4] == xpar(256'(h), 4) && tx_pfx_par[s] == ^p,
                                "R8 hdr/pfx parity", 256'({tx_hdr_par[s*4 +: 4], tx_pfx_par[s]}),
                                256'({xpar(256'(h), 4)}));
                        end
                    end else begin
                        chk(!open_b, "R4 idle inside packet", 256'(s), 256'(0));
                    end
                end
                lay_q.push_back(code);
            end
        end
    end

    // driver: sends one packet, pushing its expected beats to the scoreboard
    task automatic send_pkt(input int len, input bit pe, input int gap);
        int eff;
        logic [127:0] h;
        eff = (len == 0) ? 1 : len;
        h = {$urandom, $urandom, $urandom, $urandom};
        for (int b = 0; b < eff; b++) begin
            exp_t e;
            logic [255:0] d;
            logic [31:0] p;
            if (b == eff - 1 && gap > 0) begin
                in_valid = 1'b0;
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk(tx_dvalid == '0, "R10 store-and-forward", 256'(tx_dvalid), 256'(0));
                    @(posedge clk); #1;
                end
            end
            d = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            p = $urandom;
            in_valid  = 1'b1;
            in_data   = d;
            in_len    = LEN_W'(len);
            in_hdr    = (b == 0) ? h : {$urandom, $urandom, $urandom, $urandom};
            in_pfx_en = pe;
            in_pfx    = p;
            e.data = d; e.sop = (b == 0); e.eop = (b == eff - 1);
            e.hdr = h; e.pe = pe; e.pfx = pe ? p : 32'h0;
            exp_q.push_back(e);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic chk_lay(input int i, input logic [31:0] exp, input string tag);
        logic [31:0] act;
        act = (i < lay_q.size()) ? lay_q[i] : "????";
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s word %0d act=%s exp=%s", tag, i, act, exp);
        end
    endtask

    task automatic release_and_drain(input int n);
        tx_ready = 1'b1;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_dvalid == '0 && tx_sop == '0 && tx_eop == '0, "R1 flags", 256'({tx_dvalid, tx_sop, tx_eop}), 256'(0));
        chk(tx_data_par == '0 && tx_hdr_par == '0 && tx_pfx_par == '0, "R1 parity", 256'(tx_data_par), 256'(0));
        chk(in_ready == 1'b1, "R1 in_ready", 256'(in_ready), 256'(1));
        @(posedge clk); #1;

        // R5 and R3: short packets queued behind a stall
        tx_ready = 1'b0;
        lay_q.delete();
        send_pkt(1, 1'b1, 0);
        send_pkt(1, 1'b0, 0);
        send_pkt(1, 1'b1, 0);
        send_pkt(2, 1'b0, 0);
        send_pkt(3, 1'b1, 0);
        release_and_drain(10);
        chk_lay(0, "B.B.", "R5 pad after seg0 end");
        chk_lay(1, "B.SE", "R3 two packets");
        chk_lay(2, "SCE.", "R3 pad after seg2 end");
        chk(lay_q.size() == 3, "R5 word count", 256'(lay_q.size()), 256'(3));

        // R3 and R4: long packets crossing words
        tx_ready = 1'b0;
        lay_q.delete();
        send_pkt(4, 1'b0, 0);
        send_pkt(2, 1'b1, 0);
        send_pkt(5, 1'b0, 0);
        release_and_drain(10);
        chk_lay(0, "SCCE", "R4 full word");
        chk_lay(1, "SESC", "R3 start at seg2");
        chk_lay(2, "CCE.", "R4 continuation");

        // R10 buffer full with a maximum-length packet
        tx_ready = 1'b0;
        lay_q.delete();
        send_pkt(DEPTH, 1'b1, 0);
        @(negedge clk);
        chk(in_ready == 1'b0, "R10 full", 256'(in_ready), 256'(0));
        @(posedge clk); #1;
        release_and_drain(10);
        chk_lay(0, "SCCC", "R2 long packet");
        chk_lay(3, "CCCE", "R2 long packet end");
        chk(in_ready == 1'b1, "R10 drained", 256'(in_ready), 256'(1));

        // R10 store-and-forward with an input gap
        send_pkt(3, 1'b0, 6);
        repeat (6) @(posedge clk);
        #1;

        // R2 length 0 treated as one beat, R9 random stalls, R11 ordering
        tog_on = 1'b1;
        fork
            begin
                while (tog_on) begin
                    @(posedge clk); #1;
                    tx_ready = ($urandom % 3) != 0;
                end
            end
        join_none
        send_pkt(0, 1'b1, 0);
        for (int i = 0; i < 40; i++) send_pkt($urandom % 7, 1'($urandom % 2), 0);
        tog_on = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        release_and_drain(40);
        chk(exp_q.size() == 0, "R11 all beats delivered", 256'(exp_q.size()), 256'(0));
        chk(!open_b, "R2 last packet closed", 256'(open_b), 256'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule